// File: doc/BRIEF.md
# Pull-Model Message Transfer Controller

This controller moves datagrams between processing nodes that share a bus. The sender never pushes the payload. It only announces where the payload sits, and the receiver fetches it. On the transmit side, the local CPU first builds a datagram in its own memory. It then posts a send request that carries a destination network address, the buffer address and the length in words. Requests wait in an in-order queue. The head request's network address is resolved through a small mapping table into the bus identifier of the destination node. A short notice is then posted to that node. The notice carries the buffer address, the length and the sender's own bus identifier.

On the receive side, incoming notices wait in a FIFO. A DMA sequencer reads each announced buffer across the bus in bursts and writes the words into local memory at a running write pointer. When the last word lands, it flags a message-received interrupt. It then sends an acknowledge back to the announcing node. When an acknowledge reaches the sender, the sender flags a buffer-free interrupt and may announce its next queued message. Only one announcement is outstanding at a time.

The bus read path and the local memory are modelled as simple request/grant and write ports. Software interaction is limited to loading the mapping table and clearing status bits.

Top module: `pull_msg_ctrl`

## Requirements
- R1: Send requests are accepted while fewer than SQ_DEPTH are waiting and are announced strictly in arrival order; `req_ready` is low while the queue holds SQ_DEPTH entries.
- R2: The destination network address of the head request is matched against the mapping table written through the `cfg_*` port (lowest matching valid entry wins); the notice's `ntc_out_dst` is the mapped bus id and `ntc_out_src` equals SELF_BUS.
- R3: A request whose network address matches no valid entry is discarded without any notice, and status bit 2 (lookup miss) is set.
- R4: A notice carries the request's buffer address and length and holds all its fields stable while `ntc_out_valid` is high and `ntc_out_ready` is low; no further notice is posted until an acknowledge arrives on `ack_in_valid`.
- R5: For each received notice, the controller reads `len` consecutive words starting at the notice address and writes them, in order, to consecutive local addresses starting at a write pointer that begins at 0 and advances by `len` per message; a zero-length message writes nothing.
- R6: At most BURST words are transferred per bus tenure; after BURST granted words `rd_req` drops for at least one cycle before the next word of the same message is requested.
- R7: While `rd_req` is high and `rd_gnt` is low, no local write occurs, `rd_req` stays high and `rd_addr` holds its value.
- R8: After the last word of a message is written, `ack_out_valid` rises with `ack_out_dst` equal to the notice's source bus id and stays high until `ack_out_ready`.
- R9: Status bit 0 is set when a pull completes and bit 1 when an acknowledge arrives while awaiting one; `irq_rx` and `irq_tx` follow bits 0 and 1 as levels, and each bit clears only when `sts_clr_we` is high with a one in that bit of `sts_clr` (a set in the same cycle wins).
- R10: Incoming notices are buffered in a NQ_DEPTH-entry FIFO; `ntc_in_ready` is low while it is full, and every accepted notice is eventually pulled and acknowledged in arrival order.
- R11: After reset, `status` is 0, both interrupts are low, no notice, acknowledge, bus request or memory write is active, and both `req_ready` and `ntc_in_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | CPU send request valid |
| req_ready | output | 1 | Send queue can accept |
| req_net | input | NET_W | Destination network address |
| req_addr | input | ADDR_W | Local buffer address of the datagram |
| req_len | input | LEN_W | Datagram length in words |
| cfg_we | input | 1 | Mapping entry write strobe |
| cfg_idx | input | $clog2(MAP_N) | Mapping entry index |
| cfg_net | input | NET_W | Network address of the entry |
| cfg_bus | input | BUS_W | Bus id of the entry |
| ntc_out_valid | output | 1 | Outgoing notice valid |
| ntc_out_ready | input | 1 | Outgoing notice taken |
| ntc_out_dst | output | BUS_W | Bus id of the destination node |
| ntc_out_src | output | BUS_W | Own bus id (SELF_BUS) |
| ntc_out_addr | output | ADDR_W | Buffer address to pull from |
| ntc_out_len | output | LEN_W | Words to pull |
| ntc_in_valid | input | 1 | Incoming notice valid |
| ntc_in_ready | output | 1 | Notice FIFO can accept |
| ntc_in_src | input | BUS_W | Bus id of the announcing node |
| ntc_in_addr | input | ADDR_W | Remote buffer address |
| ntc_in_len | input | LEN_W | Remote buffer length in words |
| rd_req | output | 1 | Bus read request |
| rd_gnt | input | 1 | Bus grant; a word moves when request and grant are both high |
| rd_addr | output | ADDR_W | Remote word address |
| rd_data | input | DATA_W | Remote word returned in the granted cycle |
| mem_we | output | 1 | Local memory write strobe |
| mem_addr | output | ADDR_W | Local memory write address |
| mem_wdata | output | DATA_W | Local memory write data |
| ack_out_valid | output | 1 | Acknowledge to announcing node valid |
| ack_out_ready | input | 1 | Acknowledge taken |
| ack_out_dst | output | BUS_W | Bus id the acknowledge goes to |
| ack_in_valid | input | 1 | Acknowledge from the remote receiver |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr | input | 3 | Write-one-to-clear mask for status |
| status | output | 3 | Bit 0 received, bit 1 buffer free, bit 2 lookup miss |
| irq_rx | output | 1 | Message-received interrupt (level) |
| irq_tx | output | 1 | Buffer-free interrupt (level) |

## Verification
The bench builds the controller with BURST=4, SQ_DEPTH=2, NQ_DEPTH=2, MAP_N=4 and SELF_BUS=2. A four-word burst cap means messages of up to nine words already cross two burst boundaries, and random grant withdrawal lands inside bursts. With two-entry queues, the bench fills the send queue behind an unacknowledged notice and fills the notice FIFO behind a stalled acknowledge within a handful of cycles. This shows full-queue stalls and the lossless in-order drain without long runs.

// File: rtl/pull_msg_pkg.sv
package pull_msg_pkg;
  typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_WAIT} tx_st_e;
  typedef enum logic [1:0] {RX_IDLE, RX_PULL, RX_ACK} rx_st_e;
  localparam int ST_RX   = 0;
  localparam int ST_TX   = 1;
  localparam int ST_MISS = 2;
  localparam int ST_W    = 3;
endpackage

// File: rtl/pull_msg_fifo.sv
module pull_msg_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign dout  = mem_q[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (pop)  rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wp_q] <= din;
  end

  // R1 and R10: the queue never holds more than its depth and is never read empty
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> cnt_q <= CW'(DEPTH));
  assert_no_underflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/pull_msg_map.sv
module pull_msg_map #(
  parameter int NET_W = 8,
  parameter int BUS_W = 4,
  parameter int MAP_N = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [$clog2(MAP_N)-1:0] cfg_idx,
  input  logic [NET_W-1:0]         cfg_net,
  input  logic [BUS_W-1:0]         cfg_bus,
  input  logic [NET_W-1:0]         look_net,
  output logic                     hit,
  output logic [BUS_W-1:0]         hit_bus
);
  localparam int IW = $clog2(MAP_N);

  logic [MAP_N-1:0] vld_q;
  logic [NET_W-1:0] net_q [MAP_N];
  logic [BUS_W-1:0] bus_q [MAP_N];

  for (genvar g = 0; g < MAP_N; g++) begin : g_entry
    logic wr_en;
    assign wr_en = cfg_we && (cfg_idx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        net_q[g] <= '0;
        bus_q[g] <= '0;
      end else if (wr_en) begin
        vld_q[g] <= 1'b1;
        net_q[g] <= cfg_net;
        bus_q[g] <= cfg_bus;
      end
    end
  end

  // lowest index wins: scan from the top down so lower entries overwrite
  always_comb begin
    hit     = 1'b0;
    hit_bus = '0;
    for (int i = MAP_N - 1; i >= 0; i--) begin
      if (vld_q[i] && (net_q[i] == look_net)) begin
        hit     = 1'b1;
        hit_bus = bus_q[i];
      end
    end
  end
endmodule

// File: rtl/pull_msg_dma.sv
module pull_msg_dma #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8,
  parameter int BURST  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [LEN_W-1:0]  len,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_gnt,
  input  logic [DATA_W-1:0] rd_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              done
);
  localparam int BW = $clog2(BURST + 1);

  logic              busy_q, busy_d, gap_q, gap_d;
  logic [ADDR_W-1:0] src_q, src_d, dst_q, dst_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [BW-1:0]     bc_q, bc_d;
  logic              beat;

  assign rd_req    = busy_q && !gap_q && (rem_q != '0);
  assign rd_addr   = src_q;
  assign beat      = rd_req && rd_gnt;
  assign mem_we    = beat;
  assign mem_addr  = dst_q;
  assign mem_wdata = rd_data;
  assign done      = busy_q && (rem_q == '0);

  always_comb begin
    busy_d = busy_q;
    gap_d  = gap_q;
    src_d  = src_q;
    dst_d  = dst_q;
    rem_d  = rem_q;
    bc_d   = bc_q;
    if (start) begin
      busy_d = 1'b1;
      gap_d  = 1'b0;
      src_d  = src_addr;
      dst_d  = dst_addr;
      rem_d  = len;
      bc_d   = '0;
    end else if (done) begin
      busy_d = 1'b0;
    end else if (gap_q) begin
      gap_d = 1'b0;
    end else if (beat) begin
      src_d = src_q + 1'b1;
      dst_d = dst_q + 1'b1;
      rem_d = rem_q - 1'b1;
      if (bc_q == BW'(BURST - 1) || rem_q == LEN_W'(1)) begin
        bc_d  = '0;
        gap_d = (rem_q != LEN_W'(1));
      end else begin
        bc_d = bc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      gap_q  <= 1'b0;
      src_q  <= '0;
      dst_q  <= '0;
      rem_q  <= '0;
      bc_q   <= '0;
    end else begin
      busy_q <= busy_d;
      gap_q  <= gap_d;
      src_q  <= src_d;
      dst_q  <= dst_d;
      rem_q  <= rem_d;
      bc_q   <= bc_d;
    end
  end

  // independent run counter: granted words since rd_req was last low
  logic [BW:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (!rd_req) run_q <= '0;
    else if (beat)   run_q <= run_q + 1'b1;
  end

  assert_burst_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> run_q < (BW+1)'(BURST));
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_gnt) |=> (rd_req && $stable(rd_addr)));
endmodule

// File: rtl/pull_msg_ctrl.sv
module pull_msg_ctrl
  import pull_msg_pkg::*;
#(
  parameter int NET_W    = 8,
  parameter int BUS_W    = 4,
  parameter int ADDR_W   = 16,
  parameter int LEN_W    = 8,
  parameter int DATA_W   = 32,
  parameter int MAP_N    = 8,
  parameter int SQ_DEPTH = 4,
  parameter int NQ_DEPTH = 4,
  parameter int BURST    = 16,
  parameter int SELF_BUS = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [NET_W-1:0]         req_net,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [LEN_W-1:0]         req_len,
  input  logic                     cfg_we,
  input  logic [$clog2(MAP_N)-1:0] cfg_idx,
  input  logic [NET_W-1:0]         cfg_net,
  input  logic [BUS_W-1:0]         cfg_bus,
  output logic                     ntc_out_valid,
  input  logic                     ntc_out_ready,
  output logic [BUS_W-1:0]         ntc_out_dst,
  output logic [BUS_W-1:0]         ntc_out_src,
  output logic [ADDR_W-1:0]        ntc_out_addr,
  output logic [LEN_W-1:0]         ntc_out_len,
  input  logic                     ntc_in_valid,
  output logic                     ntc_in_ready,
  input  logic [BUS_W-1:0]         ntc_in_src,
  input  logic [ADDR_W-1:0]        ntc_in_addr,
  input  logic [LEN_W-1:0]         ntc_in_len,
  output logic                     rd_req,
  input  logic                     rd_gnt,
  output logic [ADDR_W-1:0]        rd_addr,
  input  logic [DATA_W-1:0]        rd_data,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [DATA_W-1:0]        mem_wdata,
  output logic                     ack_out_valid,
  input  logic                     ack_out_ready,
  output logic [BUS_W-1:0]         ack_out_dst,
  input  logic                     ack_in_valid,
  input  logic                     sts_clr_we,
  input  logic [ST_W-1:0]          sts_clr,
  output logic [ST_W-1:0]          status,
  output logic                     irq_rx,
  output logic                     irq_tx
);
  localparam int SQ_W = NET_W + ADDR_W + LEN_W;
  localparam int NQ_W = BUS_W + ADDR_W + LEN_W;

  // reset: asserted asynchronously, released through two flops
  logic rst_s1_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_ni   <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_ni   <= rst_s1_q;
    end
  end

  // ---------------- transmit side ----------------
  logic              sq_push, sq_pop, sq_full, sq_empty;
  logic [SQ_W-1:0]   sq_head;
  logic [NET_W-1:0]  hd_net;
  logic [ADDR_W-1:0] hd_addr;
  logic [LEN_W-1:0]  hd_len;
  logic              map_hit;
  logic [BUS_W-1:0]  map_bus;

  assign req_ready = !sq_full;
  assign sq_push   = req_valid && !sq_full;
  assign {hd_net, hd_addr, hd_len} = sq_head;

  pull_msg_fifo #(.W(SQ_W), .DEPTH(SQ_DEPTH)) u_sq (
    .clk(clk), .rst_n(rst_ni), .push(sq_push), .din({req_net, req_addr, req_len}),
    .pop(sq_pop), .dout(sq_head), .full(sq_full), .empty(sq_empty));

  pull_msg_map #(.NET_W(NET_W), .BUS_W(BUS_W), .MAP_N(MAP_N)) u_map (
    .clk(clk), .rst_n(rst_ni), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_net(cfg_net), .cfg_bus(cfg_bus), .look_net(hd_net),
    .hit(map_hit), .hit_bus(map_bus));

  tx_st_e            tx_q, tx_d;
  logic [BUS_W-1:0]  nd_q, nd_d;
  logic [ADDR_W-1:0] na_q, na_d;
  logic [LEN_W-1:0]  nl_q, nl_d;
  logic              set_tx, set_miss;

  always_comb begin
    tx_d     = tx_q;
    nd_d     = nd_q;
    na_d     = na_q;
    nl_d     = nl_q;
    sq_pop   = 1'b0;
    set_tx   = 1'b0;
    set_miss = 1'b0;
    unique case (tx_q)
      TX_IDLE: if (!sq_empty) begin
        sq_pop = 1'b1;
        if (map_hit) begin
          nd_d = map_bus;
          na_d = hd_addr;
          nl_d = hd_len;
          tx_d = TX_SEND;
        end else begin
          set_miss = 1'b1;
        end
      end
      TX_SEND: if (ntc_out_ready) tx_d = TX_WAIT;
      TX_WAIT: if (ack_in_valid) begin
        set_tx = 1'b1;
        tx_d   = TX_IDLE;
      end
      default: tx_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= TX_IDLE;
      nd_q <= '0;
      na_q <= '0;
      nl_q <= '0;
    end else begin
      tx_q <= tx_d;
      nd_q <= nd_d;
      na_q <= na_d;
      nl_q <= nl_d;
    end
  end

  assign ntc_out_valid = (tx_q == TX_SEND);
  assign ntc_out_dst   = nd_q;
  assign ntc_out_src   = BUS_W'(SELF_BUS);
  assign ntc_out_addr  = na_q;
  assign ntc_out_len   = nl_q;

  // ---------------- receive side ----------------
  logic              nq_push, nq_pop, nq_full, nq_empty;
  logic [NQ_W-1:0]   nq_head;
  logic [BUS_W-1:0]  nh_src;
  logic [ADDR_W-1:0] nh_addr;
  logic [LEN_W-1:0]  nh_len;

  assign ntc_in_ready = !nq_full;
  assign nq_push      = ntc_in_valid && !nq_full;
  assign {nh_src, nh_addr, nh_len} = nq_head;

  pull_msg_fifo #(.W(NQ_W), .DEPTH(NQ_DEPTH)) u_nq (
    .clk(clk), .rst_n(rst_ni), .push(nq_push), .din({ntc_in_src, ntc_in_addr, ntc_in_len}),
    .pop(nq_pop), .dout(nq_head), .full(nq_full), .empty(nq_empty));

  rx_st_e            rx_q, rx_d;
  logic [BUS_W-1:0]  rs_q, rs_d;
  logic [ADDR_W-1:0] wp_q, wp_d;
  logic              dma_done, set_rx;

  always_comb begin
    rx_d   = rx_q;
    rs_d   = rs_q;
    wp_d   = wp_q;
    nq_pop = 1'b0;
    set_rx = 1'b0;
    unique case (rx_q)
      RX_IDLE: if (!nq_empty) begin
        nq_pop = 1'b1;
        rs_d   = nh_src;
        wp_d   = wp_q + ADDR_W'(nh_len);
        rx_d   = RX_PULL;
      end
      RX_PULL: if (dma_done) begin
        set_rx = 1'b1;
        rx_d   = RX_ACK;
      end
      RX_ACK: if (ack_out_ready) rx_d = RX_IDLE;
      default: rx_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q <= RX_IDLE;
      rs_q <= '0;
      wp_q <= '0;
    end else begin
      rx_q <= rx_d;
      rs_q <= rs_d;
      wp_q <= wp_d;
    end
  end

  pull_msg_dma #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .BURST(BURST)) u_dma (
    .clk(clk), .rst_n(rst_ni), .start(nq_pop), .src_addr(nh_addr), .dst_addr(wp_q),
    .len(nh_len), .rd_req(rd_req), .rd_addr(rd_addr), .rd_gnt(rd_gnt), .rd_data(rd_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(dma_done));

  assign ack_out_valid = (rx_q == RX_ACK);
  assign ack_out_dst   = rs_q;

  // ---------------- status and interrupts ----------------
  logic [ST_W-1:0] st_q, st_d, st_set;

  always_comb begin
    st_set          = '0;
    st_set[ST_RX]   = set_rx;
    st_set[ST_TX]   = set_tx;
    st_set[ST_MISS] = set_miss;
    st_d = (st_q & ~(sts_clr_we ? sts_clr : '0)) | st_set;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign status = st_q;
  assign irq_rx = st_q[ST_RX];
  assign irq_tx = st_q[ST_TX];

  assert_notice_hold_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (ntc_out_valid && !ntc_out_ready) |=>
      (ntc_out_valid && $stable(ntc_out_dst) && $stable(ntc_out_addr) && $stable(ntc_out_len)));
  assert_ack_hold_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (ack_out_valid && !ack_out_ready) |=> (ack_out_valid && $stable(ack_out_dst)));
  assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (irq_rx && !(sts_clr_we && sts_clr[ST_RX])) |=> irq_rx);
  assert_miss_silent_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (!ntc_out_valid && !map_hit && !sq_empty && tx_q == TX_IDLE) |=> !ntc_out_valid);
endmodule

// File: tb/pull_msg_ctrl_tb.sv
`timescale 1ns/1ps
module pull_msg_ctrl_tb;
  localparam int NET_W = 8, BUS_W = 4, ADDR_W = 16, LEN_W = 8, DATA_W = 32;
  localparam int MAP_N = 4, SQ_DEPTH = 2, NQ_DEPTH = 2, BURST = 4, SELF_BUS = 2;
  localparam int NMSG = 17;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_ready;
  logic [NET_W-1:0] req_net = 0; logic [ADDR_W-1:0] req_addr = 0; logic [LEN_W-1:0] req_len = 0;
  logic cfg_we = 0; logic [1:0] cfg_idx = 0; logic [NET_W-1:0] cfg_net = 0; logic [BUS_W-1:0] cfg_bus = 0;
  logic ntc_out_valid, ntc_out_ready = 0;
  logic [BUS_W-1:0] ntc_out_dst, ntc_out_src; logic [ADDR_W-1:0] ntc_out_addr; logic [LEN_W-1:0] ntc_out_len;
  logic ntc_in_valid = 0, ntc_in_ready;
  logic [BUS_W-1:0] ntc_in_src = 0; logic [ADDR_W-1:0] ntc_in_addr = 0; logic [LEN_W-1:0] ntc_in_len = 0;
  logic rd_req, rd_gnt = 0; logic [ADDR_W-1:0] rd_addr; logic [DATA_W-1:0] rd_data;
  logic mem_we; logic [ADDR_W-1:0] mem_addr; logic [DATA_W-1:0] mem_wdata;
  logic ack_out_valid, ack_out_ready = 0; logic [BUS_W-1:0] ack_out_dst;
  logic ack_in_valid = 0, sts_clr_we = 0; logic [2:0] sts_clr = 0, status;
  logic irq_rx, irq_tx;

  pull_msg_ctrl #(.NET_W(NET_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W),
    .MAP_N(MAP_N), .SQ_DEPTH(SQ_DEPTH), .NQ_DEPTH(NQ_DEPTH), .BURST(BURST), .SELF_BUS(SELF_BUS)) u_dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_net, .req_addr, .req_len,
    .cfg_we, .cfg_idx, .cfg_net, .cfg_bus,
    .ntc_out_valid, .ntc_out_ready, .ntc_out_dst, .ntc_out_src, .ntc_out_addr, .ntc_out_len,
    .ntc_in_valid, .ntc_in_ready, .ntc_in_src, .ntc_in_addr, .ntc_in_len,
    .rd_req, .rd_gnt, .rd_addr, .rd_data, .mem_we, .mem_addr, .mem_wdata,
    .ack_out_valid, .ack_out_ready, .ack_out_dst, .ack_in_valid,
    .sts_clr_we, .sts_clr, .status, .irq_rx, .irq_tx);

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // remote memory model: word content derived from its address
  function automatic logic [DATA_W-1:0] remote_word(input logic [ADDR_W-1:0] a);
    return {a ^ 16'h5A3C, ~a};
  endfunction
  assign rd_data = remote_word(rd_addr);

  // grant and acknowledge-ready drivers: 0 = low, 1 = high, 2 = random
  int gnt_mode = 1, ack_mode = 1;
  always begin
    @(posedge clk); #1;
    rd_gnt        = (gnt_mode == 2) ? ($urandom % 4 != 0) : (gnt_mode == 1);
    ack_out_ready = (ack_mode == 2) ? ($urandom % 3 != 0) : (ack_mode == 1);
  end

  // notices sent to the receiver, in acceptance order
  logic [BUS_W-1:0]  nt_src  [NMSG];
  logic [ADDR_W-1:0] nt_addr [NMSG];
  logic [LEN_W-1:0]  nt_len  [NMSG];
  int nt_acc = 0;

  // receive monitor: expected write pointer, message and word cursors
  int msg_i = 0, word_j = 0, run = 0;
  logic [ADDR_W-1:0] exp_ptr = 0, stall_addr = 0;
  bit stall_prev = 0;
  always @(negedge clk) if (rst_n) begin
    if (stall_prev)
      chk(rd_req && rd_addr == stall_addr, "R7", "stall hold rd_addr", {47'd0, rd_req, rd_addr}, {47'd1, stall_addr});
    stall_prev = rd_req && !rd_gnt;
    stall_addr = rd_addr;
    if (mem_we && !rd_gnt) chk(0, "R7", "write without grant", 1, 0);
    if (!rd_req) run = 0;
    else if (rd_gnt) begin
      run++;
      if (run > BURST) chk(0, "R6", "burst length", run, BURST);
    end
    if (mem_we) begin
      chk(msg_i < nt_acc, "R5", "write with no notice pending", msg_i, nt_acc);
      chk(mem_addr == exp_ptr, "R5", "local write address", mem_addr, exp_ptr);
      chk(mem_wdata == remote_word(nt_addr[msg_i] + ADDR_W'(word_j)), "R5", "local write data",
          mem_wdata, remote_word(nt_addr[msg_i] + ADDR_W'(word_j)));
      exp_ptr++;
      word_j++;
    end
    if (ack_out_valid && ack_out_ready) begin
      chk(ack_out_dst == nt_src[msg_i], "R8", "ack destination", ack_out_dst, nt_src[msg_i]);
      chk(word_j == int'(nt_len[msg_i]), "R10", "words before ack", word_j, nt_len[msg_i]);
      msg_i++;
      word_j = 0;
    end
  end

  task automatic push_req(input logic [NET_W-1:0] n, input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] l);
    bit took = 0;
    @(posedge clk); #1;
    req_valid = 1; req_net = n; req_addr = a; req_len = l;
    while (!took) begin @(negedge clk); took = req_ready; @(posedge clk); #1; end
    req_valid = 0;
  endtask

  task automatic push_ntc(input logic [BUS_W-1:0] s, input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] l);
    bit took = 0;
    @(posedge clk); #1;
    ntc_in_valid = 1; ntc_in_src = s; ntc_in_addr = a; ntc_in_len = l;
    while (!took) begin @(negedge clk); took = ntc_in_ready; @(posedge clk); #1; end
    nt_src[nt_acc] = s; nt_addr[nt_acc] = a; nt_len[nt_acc] = l;
    nt_acc++;
    ntc_in_valid = 0;
  endtask

  task automatic pulse(ref logic sig);
    @(posedge clk); #1; sig = 1;
    @(posedge clk); #1; sig = 0;
  endtask

  task automatic clear_sts(input logic [2:0] m);
    @(posedge clk); #1; sts_clr_we = 1; sts_clr = m;
    @(posedge clk); #1; sts_clr_we = 0; sts_clr = 0;
  endtask

  task automatic cfg(input logic [1:0] i, input logic [NET_W-1:0] n, input logic [BUS_W-1:0] b);
    @(posedge clk); #1; cfg_we = 1; cfg_idx = i; cfg_net = n; cfg_bus = b;
    @(posedge clk); #1; cfg_we = 0;
  endtask

  task automatic accept_notice();
    @(posedge clk); #1; ntc_out_ready = 1;
    @(posedge clk); #1; ntc_out_ready = 0;
  endtask

  task automatic expect_notice(input string req, input logic [BUS_W-1:0] d,
                               input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] l);
    @(negedge clk);
    chk(ntc_out_valid, req, "notice valid", ntc_out_valid, 1);
    chk(ntc_out_dst == d && ntc_out_src == BUS_W'(SELF_BUS), req, "notice dst/src",
        {ntc_out_dst, ntc_out_src}, {d, BUS_W'(SELF_BUS)});
    chk(ntc_out_addr == a && ntc_out_len == l, req, "notice addr/len",
        {ntc_out_addr, ntc_out_len}, {a, l});
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    gnt_mode = 0; ack_mode = 0;
    wait_cyc(3); #1 rst_n = 1;
    wait_cyc(4);
    @(negedge clk);
    // R11: reset state
    chk(status == 0 && !irq_rx && !irq_tx, "R11", "status/irq after reset", {status, irq_rx, irq_tx}, 0);
    chk(!ntc_out_valid && !ack_out_valid && !rd_req && !mem_we, "R11", "idle outputs",
        {ntc_out_valid, ack_out_valid, rd_req, mem_we}, 0);
    chk(req_ready && ntc_in_ready, "R11", "ready after reset", {req_ready, ntc_in_ready}, 2'b11);

    // transmit side
    cfg(2'd0, 8'h10, 4'd3);
    cfg(2'd1, 8'h22, 4'd5);
    cfg(2'd3, 8'h22, 4'd9);                 // shadowed by lower entry 1
    push_req(8'h22, 16'h0100, 8'd7);
    wait_cyc(3);
    expect_notice("R2", 4'd5, 16'h0100, 8'd7);
    wait_cyc(3);
    expect_notice("R4", 4'd5, 16'h0100, 8'd7); // held while not accepted
    accept_notice();
    push_req(8'h10, 16'h0200, 8'd4);
    wait_cyc(4); @(negedge clk);
    chk(!ntc_out_valid && status[1] == 0, "R4", "no second notice before ack", {ntc_out_valid, status[1]}, 0);
    pulse(ack_in_valid);
    @(negedge clk);
    chk(status[1] && irq_tx, "R9", "buffer-free irq on ack", {status[1], irq_tx}, 2'b11);
    wait_cyc(3);
    expect_notice("R1", 4'd3, 16'h0200, 8'd4);
    accept_notice();
    push_req(8'h22, 16'h0300, 8'd1);
    push_req(8'h10, 16'h0400, 8'd2);
    @(negedge clk);
    chk(!req_ready, "R1", "send queue full", req_ready, 0);
    pulse(ack_in_valid);
    wait_cyc(3);
    expect_notice("R1", 4'd5, 16'h0300, 8'd1);
    chk(irq_tx, "R9", "irq_tx stays set without clear", irq_tx, 1);
    accept_notice();
    pulse(ack_in_valid);
    wait_cyc(3);
    expect_notice("R1", 4'd3, 16'h0400, 8'd2);
    accept_notice();
    pulse(ack_in_valid);
    clear_sts(3'b010);
    @(negedge clk);
    chk(status == 0 && !irq_tx, "R9", "write-one-to-clear tx", status, 0);
    push_req(8'h77, 16'h0500, 8'd3);
    wait_cyc(4); @(negedge clk);
    chk(status == 3'b100 && !ntc_out_valid, "R3", "lookup miss dropped", {status, ntc_out_valid}, 4'b1000);
    clear_sts(3'b001);                      // clearing an unrelated bit leaves miss set
    @(negedge clk);
    chk(status == 3'b100, "R9", "clear with zero mask bit", status, 3'b100);
    clear_sts(3'b100);
    @(negedge clk);
    chk(status == 0, "R3", "miss bit cleared", status, 0);

    // receive side, directed: full grant, single message of 3 words
    gnt_mode = 1; ack_mode = 1;
    push_ntc(4'd7, 16'h1000, 8'd3);
    wait_cyc(15); @(negedge clk);
    chk(msg_i == 1 && exp_ptr == 16'd3, "R5", "first message pulled", {msg_i[15:0], exp_ptr}, {16'd1, 16'd3});
    chk(status[0] && irq_rx, "R9", "message-received irq", {status[0], irq_rx}, 2'b11);
    clear_sts(3'b001);
    @(negedge clk);
    chk(!irq_rx, "R9", "irq_rx cleared", irq_rx, 0);

    // backpressure: acknowledges held off, random grant
    gnt_mode = 2; ack_mode = 0;
    fork
      begin
        push_ntc(4'd4, 16'h2000, 8'd5);
        for (int k = 2; k < NMSG; k++)
          push_ntc(BUS_W'($urandom), ADDR_W'($urandom), LEN_W'($urandom % 10));
      end
    join_none
    wait_cyc(60); @(negedge clk);
    chk(nt_acc == 1 + 1 + NQ_DEPTH, "R10", "notices accepted while ack stalled", nt_acc, 2 + NQ_DEPTH);
    chk(!ntc_in_ready, "R10", "notice FIFO backpressure", ntc_in_ready, 0);
    chk(ack_out_valid && ack_out_dst == 4'd4, "R8", "ack held for source 4", {ack_out_valid, ack_out_dst}, {1'b1, 4'd4});
    ack_mode = 2;
    while (msg_i < NMSG) @(posedge clk);
    @(negedge clk);
    chk(msg_i == NMSG && nt_acc == NMSG, "R10", "all notices acknowledged in order", msg_i, NMSG);
    chk(irq_rx, "R9", "irq_rx after random run", irq_rx, 1);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", msg_i, NMSG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule